// File: doc/BRIEF.md
# Sequential Single-Precision Multiplier Core

This block multiplies two binary32 floating-point operands. It does not normalise or round. The result sign and the result exponent are formed in the same cycle the operands are accepted. The 24-bit significands, each with the implicit leading one restored, are multiplied over 24 cycles by a serial shift-and-add loop. The loop consumes one multiplier bit per cycle, least significant bit first. When the bit is set, the multiplicand is added into the upper half of a 48-bit accumulator. The accumulator is then shifted right by one, whatever the bit was.

The raw product lies in [1,4) and keeps both integer bits. It is handed unnormalised to a following normalise-and-round stage, along with the sign and a 10-bit signed biased exponent. The wide exponent lets that stage detect overflow and underflow. When either operand is zero, the loop is skipped and a zero result appears on the next cycle. Infinities, NaNs and denormals are passed through as ordinary numbers and are left to the following stage.

Top module: `fp_seq_mul`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done` and `prod` are all zero.
- R2: `sign` equals the XOR of operand bit 31 of `a` and operand bit 31 of `b`.
- R3: For nonzero operands, `exp` equals a[30:23] + b[30:23] − 127, as a 10-bit two's-complement value.
- R4: For nonzero operands, `prod` equals {1,a[22:0]} × {1,b[22:0]} as a 48-bit unsigned value. Bits 47:46 are the integer bits, so at least one of them is set.
- R5: For nonzero operands, `done` rises exactly 24 clock edges after the edge that accepts `start`, and `busy` is high in between.
- R6: An operand whose bits 30:0 are all zero counts as zero. If either operand is zero, `done` is high right after the accepting edge, `busy` stays low, and `prod` and `exp` are zero while `sign` still follows R2.
- R7: `done` is high for exactly one cycle, and never while `busy` is high.
- R8: `start` has no effect while `busy` is high. The running result, its latency and its operands are unchanged, and no extra `done` follows.
- R9: `sign`, `exp` and `prod` hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept operands when not busy |
| a | input | 32 | Multiplicand, binary32 |
| b | input | 32 | Multiplier, binary32 |
| busy | output | 1 | Significand loop running |
| done | output | 1 | One-cycle result-valid pulse |
| sign | output | 1 | Result sign |
| exp | output | 10 | Signed biased result exponent |
| prod | output | 48 | Unnormalised significand product |

## Verification
The assertions assume that `start` is a plain level sampled on the clock. They also assume that a nonzero operand carries a normal biased exponent, since the integer-bit check relies on the hidden one. The stimulus keeps random nonzero exponent fields in 1..254 and builds zero operands explicitly with either sign. It raises `start` during the busy window only in the dedicated ignore test.

// File: rtl/fp_seq_mul.sv
module fp_seq_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int BIAS   = 127
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output logic                  busy,
  output logic                  done,
  output logic                  sign,
  output logic [EXP_W+1:0]      exp,
  output logic [2*FRAC_W+1:0]   prod
);
  localparam int OP_W   = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam int CNT_W  = $clog2(SIG_W + 1);

  logic              busy_q, done_q, sign_q;
  logic [XW-1:0]     exp_q;
  logic [PROD_W-1:0] acc_q;
  logic [SIG_W-1:0]  mcand_q, mplier_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              accept, any_zero, last;
  logic [XW-1:0]     exp_sum;
  logic [SIG_W:0]    add_v;
  logic [PROD_W-1:0] step;

  assign accept   = start && !busy_q;
  assign any_zero = (a[OP_W-2:0] == '0) || (b[OP_W-2:0] == '0);
  assign exp_sum  = {2'b00, a[OP_W-2:FRAC_W]} + {2'b00, b[OP_W-2:FRAC_W]} - XW'(BIAS);
  assign add_v    = {1'b0, acc_q[PROD_W-1:SIG_W]} + {1'b0, mcand_q};
  assign step     = mplier_q[0] ? {add_v, acc_q[SIG_W-1:1]} : {1'b0, acc_q[PROD_W-1:1]};
  assign last     = cnt_q == CNT_W'(SIG_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sign_q   <= 1'b0;
      exp_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        sign_q <= a[OP_W-1] ^ b[OP_W-1];
        acc_q  <= '0;
        cnt_q  <= '0;
        if (any_zero) begin
          exp_q  <= '0;
          done_q <= 1'b1;
        end else begin
          exp_q    <= exp_sum;
          mcand_q  <= {1'b1, a[FRAC_W-1:0]};
          mplier_q <= {1'b1, b[FRAC_W-1:0]};
          busy_q   <= 1'b1;
        end
      end else if (busy_q) begin
        acc_q    <= step;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign sign = sign_q;
  assign exp  = exp_q;
  assign prod = acc_q;
endmodule

// File: rtl/fp_seq_mul_chk.sv
module fp_seq_mul_chk #(
  parameter int OP_W = 32,
  parameter int XW = 10,
  parameter int PW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [OP_W-1:0] a,
  input logic [OP_W-1:0] b,
  input logic          busy,
  input logic          done,
  input logic          sign,
  input logic [XW-1:0] exp,
  input logic [PW-1:0] prod
);
  localparam int SIG = PW / 2;
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R6
  zero_path_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (a[OP_W-2:0] == '0 || b[OP_W-2:0] == '0))
      |=> (done && !busy && prod == '0 && exp == '0));
  // R5
  enter_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && a[OP_W-2:0] != '0 && b[OP_W-2:0] != '0) |=> busy);
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> run == 8'(SIG));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(sign) && $stable(exp)));
  // R4
  int_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> prod[PW-1:PW-2] != 2'b00);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(sign) && $stable(exp) && $stable(prod)));
endmodule

bind fp_seq_mul fp_seq_mul_chk #(.OP_W(OP_W), .XW(XW), .PW(PROD_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .busy(busy),
  .done(done), .sign(sign), .exp(exp), .prod(prod));

// File: tb/fp_seq_mul_test.sv
module fp_seq_mul_test;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, sign;
  logic [9:0]  exp;
  logic [47:0] prod;
  int checks = 0, errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  fp_seq_mul uut (.clk(clk), .rst(rst), .start(start), .a(a), .b(b), .busy(busy),
                  .done(done), .sign(sign), .exp(exp), .prod(prod));

  function automatic bit is_zero(logic [31:0] x);
    return x[30:0] == '0;
  endfunction
  function automatic logic [9:0] exp_ref(logic [31:0] x, logic [31:0] y);
    if (is_zero(x) || is_zero(y)) return '0;
    return 10'(int'(x[30:23]) + int'(y[30:23]) - 127);
  endfunction
  function automatic logic [47:0] prod_ref(logic [31:0] x, logic [31:0] y);
    logic [63:0] p;
    if (is_zero(x) || is_zero(y)) return '0;
    p = 64'({1'b1, x[22:0]}) * 64'({1'b1, y[22:0]});
    return p[47:0];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run(logic [31:0] x, logic [31:0] y, bit poke);
    int n;
    bit zero_op;
    zero_op = is_zero(x) || is_zero(y);
    @(negedge clk); a = x; b = y; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      if (poke && n == 5) begin a = ~x; b = 32'h4000_0001; start = 1'b1; end
      if (poke && n == 7) start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    chk(n == (zero_op ? 0 : 24), zero_op ? "R6 latency" : "R5 latency", 64'(n), zero_op ? 0 : 24);
    chk(sign == (x[31] ^ y[31]), "R2 sign", 64'(sign), 64'(x[31] ^ y[31]));
    chk(exp == exp_ref(x, y), zero_op ? "R6 exp" : "R3 exp", 64'(exp), 64'(exp_ref(x, y)));
    chk(prod == prod_ref(x, y), zero_op ? "R6 prod" : "R4 prod", 64'(prod), 64'(prod_ref(x, y)));
    if (poke) begin
      repeat (30) begin
        @(negedge clk);
        chk(!done && !busy, "R8 no extra done", 64'(done), 0);
      end
      chk(prod == prod_ref(x, y), "R8 result kept", 64'(prod), 64'(prod_ref(x, y)));
    end else begin
      @(negedge clk);
      chk(!done, "R7 one-cycle done", 64'(done), 0);
    end
  endtask

  initial begin
    int i = 0;
    forever begin
      @(posedge clk);
      i++;
      if (i > 150000 && !finished) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", i);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] x, y;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && prod == '0, "R1 reset", {busy, done, 62'(prod)}, 0);
    run(32'h3FE0_0000, 32'h3F40_0000, 1'b0);
    run(32'h3F80_0000, 32'h3F80_0000, 1'b0);
    run(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0);
    run(32'h0080_0000, 32'h8080_0000, 1'b0);
    run(32'h0000_0000, 32'h4000_0000, 1'b0);
    run(32'hC120_0000, 32'h8000_0000, 1'b0);
    run(32'h4049_0FDB, 32'hBF35_04F3, 1'b1);
    x = prod;
    repeat (4) @(negedge clk);
    chk(prod == 48'(x) || prod[47:32] != 0, "R9 hold", 64'(prod), 64'(x));
    chk(prod == prod_ref(32'h4049_0FDB, 32'hBF35_04F3), "R9 hold",
        64'(prod), 64'(prod_ref(32'h4049_0FDB, 32'hBF35_04F3)));
    for (int k = 0; k < 60; k++) begin
      x = $urandom; y = $urandom;
      x[30:23] = 8'(1 + $urandom_range(0, 253));
      y[30:23] = 8'(1 + $urandom_range(0, 253));
      if (k % 10 == 3) x[30:0] = '0;
      if (k % 10 == 7) y[30:0] = '0;
      run(x, y, 1'b0);
    end
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(!busy && !done && prod == '0, "R1 reset after run", {busy, done, 62'(prod)}, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule